// File: doc/BRIEF.md
# Redundant Reference Selection Controller

This block decides which of two reference clocks feeds a downstream PLL. It combines a user select pin, a manual-override pin, an active-low alarm-reset pin and two sticky failure flags from an external loss detector. It returns three things: a one-cycle clear pulse that the detector uses to drop its flags, a status bit naming the reference in use, and a clock output taken from a glitch-free two-input mux.

In automatic mode the first reference to fail wins. If the failed reference is the one in use, the selection moves to the other reference and stays there. A falling edge on the alarm-reset pin clears the latch and sets the selection back to the user select. In override mode automatic switching is off and the selection always equals the select pin. The control pins are synchronized to the system clock. The mux hands over between reference domains so that no runt pulse reaches the output.

Top module: `refsel_ctrl`

## Requirements
- R1: The status output encodes the reference in use: 0 means reference 0 drives the output and 1 means reference 1 does. A select value of 0 asks for reference 0 and a value of 1 asks for reference 1.
- R2: When override is low, no failure flag is set and no latch is held, the status follows the select input within five system-clock cycles.
- R3: When override is low and the flag of the reference in use rises, the status changes to the other reference and latches there.
- R4: Once latched, the status ignores further select changes and further flag changes until an alarm reset. A failure of the reference that is not in use also latches the current selection, so the first failure wins.
- R5: A high-to-low transition on the alarm-reset input produces exactly one clear pulse, one system-clock cycle wide. Holding the input low produces no further pulse. The clear releases the latch, and the status returns to the select input.
- R6: When override is low and both flags are set while no latch is held, the status becomes 0 and latches. This includes the case where both flags are still high after an alarm reset.
- R7: While override is high, the status equals the select input whatever the flags are. When override returns low with a flag still set, the latching of R3, R4 and R6 applies again.
- R8: The clock output switches without overlap. The old reference's enable is removed on that reference's falling edge before the new reference is enabled on its own falling edge. Once the handshake has settled, the output equals the selected reference.
- R9: During and after system reset the clear output is low and no latch is held. The status then follows the select input, as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | User reference select, asynchronous |
| ovr_i | input | 1 | Manual override; 1 disables automatic switching, asynchronous |
| alarm_rst_n_i | input | 1 | Alarm reset; its falling edge clears, asynchronous |
| bad0_i | input | 1 | Sticky failure flag of reference 0, synchronous to clk |
| bad1_i | input | 1 | Sticky failure flag of reference 1, synchronous to clk |
| ref0_i | input | 1 | Reference clock 0 |
| ref1_i | input | 1 | Reference clock 1 |
| clr_pulse_o | output | 1 | One-cycle clear for the loss detector |
| sel_stat_o | output | 1 | Reference in use (0 or 1) |
| ref_clk_o | output | 1 | Glitch-free muxed reference clock |

## Verification
The assertions assume that the failure flags are synchronous to the system clock and are sticky, as a loss detector provides them. They also assume that both reference clocks keep toggling, so that the mux handshake can finish. The stimulus drives the flags on the falling system-clock edge and lowers them only just before an alarm reset, which keeps them sticky. Between changes it waits long enough for the synchronizers and both reference-domain handshakes to settle. It changes only one control at a time, so every expected status is well defined.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  localparam int unsigned NREF = 2;
  localparam logic        REF_FALLBACK = 1'b0;
  typedef logic ref_idx_t;
endpackage

// File: rtl/refsel_sync.sv
module refsel_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST_VAL;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/refsel_oneshot.sv
module refsel_oneshot (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_n,
  output logic pulse
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b1;
    else        lvl_q <= lvl_n;
  end

  // High for the single cycle in which the synchronized level first reads low.
  assign pulse = lvl_q & ~lvl_n;
endmodule

// File: rtl/refsel_decide.sv
module refsel_decide
  import refsel_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sel_s,
  input  logic     ovr_s,
  input  logic     clr,
  input  logic [NREF-1:0] bad,
  output ref_idx_t cur,
  output logic     locked
);
  ref_idx_t cur_d;
  logic     locked_d;

  always_comb begin
    cur_d    = cur;
    locked_d = locked;
    if (clr || ovr_s) begin
      cur_d    = sel_s;
      locked_d = 1'b0;
    end else if (!locked) begin
      if (&bad) begin
        cur_d    = REF_FALLBACK;
        locked_d = 1'b1;
      end else if (bad[cur]) begin
        cur_d    = ~cur;
        locked_d = 1'b1;
      end else if (|bad) begin
        locked_d = 1'b1;
      end else begin
        cur_d = sel_s;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur    <= REF_FALLBACK;
      locked <= 1'b0;
    end else begin
      cur    <= cur_d;
      locked <= locked_d;
    end
  end
endmodule

// File: rtl/refsel_gmux.sv
module refsel_gmux
  import refsel_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic            rst_n,
  input  ref_idx_t        cur,
  input  logic [NREF-1:0] ref_clk,
  output logic [NREF-1:0] gate_en,
  output logic            clk_out
);
  for (genvar i = 0; i < NREF; i++) begin : g_leg
    logic [STAGES-1:0] hs;
    logic              want;
    assign want = (cur == ref_idx_t'(i)) & ~gate_en[NREF-1-i];

    always_ff @(negedge ref_clk[i] or negedge rst_n) begin
      if (!rst_n) hs <= '0;
      else        hs <= {hs[STAGES-2:0], want};
    end
    assign gate_en[i] = hs[STAGES-1];
  end

  assign clk_out = |(ref_clk & gate_en);
endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
  import refsel_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MUX_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic ovr_i,
  input  logic alarm_rst_n_i,
  input  logic bad0_i,
  input  logic bad1_i,
  input  logic ref0_i,
  input  logic ref1_i,
  output logic clr_pulse_o,
  output logic sel_stat_o,
  output logic ref_clk_o
);
  localparam int unsigned NCTL = 3;

  logic [NCTL-1:0] ctl_s;
  logic            sel_s, ovr_s, arn_s, locked;
  ref_idx_t        cur;
  logic [NREF-1:0] gate_en;

  refsel_sync #(.W(NCTL), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({alarm_rst_n_i, ovr_i, sel_i}), .q(ctl_s)
  );
  assign {arn_s, ovr_s, sel_s} = ctl_s;

  refsel_oneshot u_shot (
    .clk(clk), .rst_n(rst_n), .lvl_n(arn_s), .pulse(clr_pulse_o)
  );

  refsel_decide u_dec (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .ovr_s(ovr_s),
    .clr(clr_pulse_o), .bad({bad1_i, bad0_i}), .cur(cur), .locked(locked)
  );

  refsel_gmux #(.STAGES(MUX_STAGES)) u_mux (
    .rst_n(rst_n), .cur(cur), .ref_clk({ref1_i, ref0_i}),
    .gate_en(gate_en), .clk_out(ref_clk_o)
  );

  assign sel_stat_o = cur;
endmodule

// File: rtl/refsel_chk.sv
module refsel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_s,
  input logic       ovr_s,
  input logic       clr,
  input logic       locked,
  input logic       bad0,
  input logic       bad1,
  input logic       stat,
  input logic [1:0] gate_en
);
  logic bad_cur;
  assign bad_cur = stat ? bad1 : bad0;

  AST_FREE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_s && !locked && !clr && !bad0 && !bad1) |=> (stat == $past(sel_s))); // R2
  AST_FAILOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_s && !locked && !clr && !(bad0 && bad1) && bad_cur) |=> (stat != $past(stat)) && locked); // R3
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !clr && !ovr_s) |=> $stable(stat)); // R4
  AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !clr); // R5
  AST_CLR_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!locked && stat == $past(sel_s))); // R5
  AST_BOTH_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_s && !locked && !clr && bad0 && bad1) |=> (stat == 1'b0 && locked)); // R6
  AST_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_s |=> (stat == $past(sel_s) && !locked)); // R7
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gate_en)); // R8
  always @(posedge clk) begin
    if (!rst_n) AST_RESET_QUIET: assert (!clr && !locked); // R9
  end
endmodule

bind refsel_ctrl refsel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .ovr_s(ovr_s), .clr(clr_pulse_o),
  .locked(locked), .bad0(bad0_i), .bad1(bad1_i), .stat(sel_stat_o), .gate_en(gate_en)
);

// File: tb/test_refsel_ctrl.sv
module test_refsel_ctrl;
  logic clk = 0, rst_n = 0;
  logic sel = 0, ovr = 0, arn = 1, b0 = 0, b1 = 0;
  logic r0 = 0, r1 = 0;
  logic clr, stat, rclk;
  int checks = 0, failures = 0;
  logic m_cur = 0, m_lock = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always #7  r0 = ~r0;
  always #13 r1 = ~r1;

  refsel_ctrl i_refsel_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .ovr_i(ovr), .alarm_rst_n_i(arn),
    .bad0_i(b0), .bad1_i(b1), .ref0_i(r0), .ref1_i(r1),
    .clr_pulse_o(clr), .sel_stat_o(stat), .ref_clk_o(rclk)
  );

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Expected selection after a settled step, from the requirements.
  function automatic logic [1:0] model(logic c, logic l, logic s, logic o, logic f0, logic f1);
    if (o) return {1'b0, s};
    if (l) return {1'b1, c};
    if (f0 && f1) return {1'b1, 1'b0};
    if ((c == 1'b0 && f0) || (c == 1'b1 && f1)) return {1'b1, ~c};
    if (f0 || f1) return {1'b1, c};
    return {1'b0, s};
  endfunction

  task automatic settle();
    repeat (14) @(negedge clk);
    {m_lock, m_cur} = model(m_cur, m_lock, sel, ovr, b0, b1);
  endtask

  task automatic check_mux(string req);
    logic hi, lo;
    if (m_cur) begin @(posedge r1); #2 hi = rclk; @(negedge r1); #2 lo = rclk; end
    else       begin @(posedge r0); #2 hi = rclk; @(negedge r0); #2 lo = rclk; end
    chk(req, hi & ~lo, 1'b1);
  endtask

  task automatic alarm(string req);
    int n = 0;
    @(negedge clk) arn = 0;
    repeat (10) begin @(negedge clk); if (clr) n++; end
    @(negedge clk) arn = 1;
    repeat (6) begin @(negedge clk); if (clr) n++; end
    checks++;
    if (n != 1) begin
      failures++;
      $display("FAIL %s pulses actual=%0d expected=1", req, n);
    end
    m_lock = 0; m_cur = sel;
    settle();
  endtask

  initial begin
    int unsigned wd = 0;
    while (!done) begin
      @(posedge clk); wd++;
      if (wd > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<=150000", wd);
        finish_run();
      end
    end
  end

  initial begin
    int unsigned r;
    r = $urandom(32'h5eed);
    sel = 1;
    repeat (4) @(negedge clk);
    chk("R9 clr low in reset", clr, 1'b0);
    rst_n = 1;
    settle();
    chk("R9 status follows select after reset", stat, 1'b1);
    chk("R1 status encodes ref1", stat, m_cur);
    check_mux("R8 output is ref1");
    sel = 0; settle();
    chk("R2 follow select 0", stat, 1'b0);
    check_mux("R8 output is ref0 after switch");
    // R3: failure of the reference in use
    b0 = 1; settle();
    chk("R3 failover to ref1", stat, 1'b1);
    check_mux("R8 output after failover");
    sel = 1; settle(); sel = 0; settle();
    chk("R4 latched ignores select", stat, 1'b1);
    b1 = 1; settle();
    chk("R4 latched ignores second flag", stat, 1'b1);
    // R6: both bad at alarm, flags stay high
    alarm("R5 single pulse");
    m_lock = 0; m_cur = sel; {m_lock, m_cur} = model(1'b0, 1'b0, sel, ovr, b0, b1);
    chk("R6 both bad falls back to ref0", stat, 1'b0);
    sel = 1; settle();
    chk("R6 stays latched on ref0", stat, 1'b0);
    b0 = 0; b1 = 0;
    alarm("R5 pulse on clean alarm");
    chk("R5 realign with select", stat, 1'b1);
    // R4: unused reference fails first
    b0 = 1; settle(); sel = 0; settle();
    chk("R4 first failure wins, unused ref", stat, 1'b1);
    // R7 override
    ovr = 1; settle();
    chk("R7 override follows select", stat, 1'b0);
    b1 = 1; sel = 1; settle();
    chk("R7 override ignores flags", stat, 1'b1);
    ovr = 0; settle();
    chk("R7 flags resume after override", stat, m_cur);
    b0 = 0; b1 = 0; alarm("R5 pulse after override");
    // random phase
    for (int k = 0; k < 40; k++) begin
      r = $urandom % 6;
      case (r)
        0, 1: sel = ~sel;
        2: ovr = ~ovr;
        3: b0 = 1;
        4: b1 = 1;
        default: begin b0 = 0; b1 = 0; end
      endcase
      if (r == 5) alarm("R5 random alarm");
      else settle();
      chk("R2 R3 R4 R6 R7 random step", stat, m_cur);
      if (k % 8 == 0) check_mux("R8 random mux");
    end
    done = 1;
    finish_run();
  end
endmodule